// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

This block has two timer channels that share one free-running 16-bit counter. Each channel has a 16-bit value register and a two-bit mode. Mode 00 makes the channel an input capture. A rising edge on the channel's input then copies the counter into the value register. Any other mode makes the channel an output compare. The counter is compared against the value register, and on a match the channel's output pin toggles. Every capture or match raises the channel's flag.

An 8-bit host reaches each 16-bit value through two byte registers, one for the upper half and one for the lower half. An interlock keeps these split accesses coherent.

- In capture mode, reading the upper byte freezes the value until the lower byte is read. A capture edge cannot tear the pair apart between the two reads.
- In compare mode, writing the upper byte suspends matching and flag setting until the lower byte is written. The channel never compares against a half-updated value.

The host sets the mode and clears the flag through a control byte per channel.

The value registers have no reset value. Software writes them, or lets a capture fill them, before using them.

Top module: `tmr_ccp_pair`

## Requirements
- R1: After reset, both compare outputs and both flags are 0. Each channel's control byte reads 0x00, which is capture mode (mode 00) with the flag clear.
- R2: The counter increments on every clock with `cnt_en` high and holds when `cnt_en` is low. It wraps from 0xFFFF to 0x0000 and starts from 0 after reset.
- R3: In capture mode (control bits [1:0] = 00), a rising edge on `cap_in[c]` loads the counter into channel c's value and sets its flag. The edge passes a two-flop synchroniser, so the value stored is the counter value two clocks after the input rises. It reads back at byte address 3c+1 (bits 15..8) and 3c+2 (bits 7..0).
- R4: In capture mode, a read of the upper byte (address 3c+1) makes the channel drop capture edges, with neither value nor flag changed. This lasts until the lower byte (address 3c+2) is read. Edges that arrive in that window are not kept.
- R5: In compare mode (control bits [1:0] nonzero), the counter equalling the channel value on a counting clock toggles `cmp_out[c]` and sets the flag.
- R6: In compare mode, a write of the upper byte stops matches and flag setting for that channel until the lower byte is written. A match missed in that window is not made up afterwards.
- R7: A write to the control byte (address 3c) loads the mode from bits [1:0] and clears both interlocks of that channel. It clears the flag when bit 7 is 0 and leaves the flag alone when bit 7 is 1. If a capture or match falls in the same cycle as a clear, the flag ends up set. The control byte reads back as flag in bit 7 and mode in bits [1:0].
- R8: The two channels are independent: an event, mode or flag operation on one has no effect on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| bus_addr | input | 3 | Byte register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte |
| cap_in | input | 2 | Capture inputs, one per channel |
| cmp_out | output | 2 | Compare outputs, one per channel |
| chan_flag | output | 2 | Event flags, one per channel |

## Verification
The bench fires a capture edge between an upper-byte read and the lower-byte read. A design without the interlock would hand back a lower byte from a newer capture than the upper byte, and would set the flag for an edge it should have dropped.

It loads a compare value through a pending upper-byte write and runs the counter past that value. A design that still compared during the window would toggle the output early. The bench also tests that the interlock releases, by scoring later toggles and the stamps they carry.

It times a flag clear into the same clock as a capture to show that the set wins. A compare across the 0xFFFF wrap proves the counter rolls over instead of saturating.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // mode encoding: all-zero selects input capture, anything else compare
  localparam logic [1:0] MODE_CAPTURE = 2'b00;

  // byte offsets inside one channel's three-byte window
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2
  } sel_e;

  localparam int unsigned SLOTS_PER_CH = 3;

  function automatic logic mode_is_capture(input logic [1:0] m);
    return m == MODE_CAPTURE;
  endfunction
endpackage

// File: rtl/tmr_rst_sync.sv
`timescale 1ns/1ps
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          cnt_en,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;   // natural wrap at all-ones
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SYNC_LEN = 2,
  localparam int CW      = 2 * DW
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          cnt_en,
  input  logic [CW-1:0] cnt,
  input  logic          cap_in,
  input  logic          sel_ctrl,
  input  logic          sel_hi,
  input  logic          sel_lo,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_byte,
  output logic [CW-1:0] val_o,
  output logic          cap_hold_o,
  output logic          cmp_hold_o,
  output logic          cmp_out,
  output logic          flag
);
  localparam int FLAG_BIT = DW - 1;

  // synchroniser plus one history stage for edge detection
  logic [SYNC_LEN:0] sync_q;
  logic [SYNC_LEN:0] sync_d;
  logic [1:0]        mode_q, mode_d;
  logic              flag_q, flag_d;
  logic              out_q, out_d;
  logic              caphold_q, caphold_d;
  logic              cmphold_q, cmphold_d;
  logic [CW-1:0]     val_q, val_d;

  logic is_cap, rise, cap_evt, cmp_evt;
  logic wr_ctrl, wr_hi, wr_lo, rd_hi, rd_lo;

  always_comb begin
    wr_ctrl = bus_wr & sel_ctrl;
    wr_hi   = bus_wr & sel_hi;
    wr_lo   = bus_wr & sel_lo;
    rd_hi   = bus_rd & sel_hi;
    rd_lo   = bus_rd & sel_lo;
    is_cap  = mode_is_capture(mode_q);
    rise    = sync_q[SYNC_LEN-1] & ~sync_q[SYNC_LEN];
    cap_evt = rise & is_cap & ~caphold_q;
    cmp_evt = ~is_cap & ~cmphold_q & cnt_en & (cnt == val_q);
  end

  always_comb begin
    sync_d = {sync_q[SYNC_LEN-1:0], cap_in};

    mode_d = wr_ctrl ? wdata[1:0] : mode_q;

    caphold_d = caphold_q;
    if (wr_ctrl)              caphold_d = 1'b0;
    else if (is_cap && rd_hi) caphold_d = 1'b1;
    else if (rd_lo)           caphold_d = 1'b0;

    cmphold_d = cmphold_q;
    if (wr_ctrl)               cmphold_d = 1'b0;
    else if (!is_cap && wr_hi) cmphold_d = 1'b1;
    else if (wr_lo)            cmphold_d = 1'b0;

    val_d = val_q;
    if (wr_hi)   val_d[CW-1:DW] = wdata;
    if (wr_lo)   val_d[DW-1:0]  = wdata;
    if (cap_evt) val_d          = cnt;

    flag_d = flag_q;
    if (wr_ctrl && !wdata[FLAG_BIT]) flag_d = 1'b0;
    if (cap_evt || cmp_evt)          flag_d = 1'b1;   // set beats clear

    out_d = out_q ^ cmp_evt;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sync_q    <= '0;
      mode_q    <= MODE_CAPTURE;
      flag_q    <= 1'b0;
      out_q     <= 1'b0;
      caphold_q <= 1'b0;
      cmphold_q <= 1'b0;
    end else begin
      sync_q    <= sync_d;
      mode_q    <= mode_d;
      flag_q    <= flag_d;
      out_q     <= out_d;
      caphold_q <= caphold_d;
      cmphold_q <= cmphold_d;
    end
  end

  // value register deliberately carries no reset
  always_ff @(posedge clk) begin
    val_q <= val_d;
  end

  assign ctrl_byte  = {flag_q, {(DW-3){1'b0}}, mode_q};
  assign val_o      = val_q;
  assign cap_hold_o = caphold_q;
  assign cmp_hold_o = cmphold_q;
  assign cmp_out    = out_q;
  assign flag       = flag_q;
endmodule

// File: rtl/tmr_ccp_pair.sv
`timescale 1ns/1ps
module tmr_ccp_pair
  import tmr_pkg::*;
#(
  parameter int  NCH = 2,
  parameter int  DW  = 8,
  localparam int AW  = $clog2(SLOTS_PER_CH * NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] cap_in,
  output logic [NCH-1:0] cmp_out,
  output logic [NCH-1:0] chan_flag
);
  localparam int CW = 2 * DW;

  logic                     srst_n;
  logic [CW-1:0]            cnt;
  logic [NCH-1:0][DW-1:0]   ctrl_b;
  logic [NCH-1:0][CW-1:0]   val_w;
  logic [NCH-1:0]           cap_hold;
  logic [NCH-1:0]           cmp_hold;
  logic [NCH-1:0]           hit_ctrl, hit_hi, hit_lo;

  tmr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  tmr_counter #(.CW(CW)) i_counter (
    .clk    (clk),
    .srst_n (srst_n),
    .cnt_en (cnt_en),
    .cnt    (cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(SLOTS_PER_CH * c);

    assign hit_ctrl[c] = (bus_addr == BASE + AW'(SEL_CTRL));
    assign hit_hi[c]   = (bus_addr == BASE + AW'(SEL_HI));
    assign hit_lo[c]   = (bus_addr == BASE + AW'(SEL_LO));

    tmr_chan #(.DW(DW), .SYNC_LEN(2)) i_chan (
      .clk        (clk),
      .srst_n     (srst_n),
      .cnt_en     (cnt_en),
      .cnt        (cnt),
      .cap_in     (cap_in[c]),
      .sel_ctrl   (hit_ctrl[c]),
      .sel_hi     (hit_hi[c]),
      .sel_lo     (hit_lo[c]),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .wdata      (bus_wdata),
      .ctrl_byte  (ctrl_b[c]),
      .val_o      (val_w[c]),
      .cap_hold_o (cap_hold[c]),
      .cmp_hold_o (cmp_hold[c]),
      .cmp_out    (cmp_out[c]),
      .flag       (chan_flag[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (hit_ctrl[c]) bus_rdata = ctrl_b[c];
      if (hit_hi[c])   bus_rdata = val_w[c][CW-1:DW];
      if (hit_lo[c])   bus_rdata = val_w[c][DW-1:0];
    end
  end
endmodule

// File: rtl/tmr_ccp_chk.sv
`timescale 1ns/1ps
module tmr_ccp_chk #(
  parameter int  NCH = 2,
  parameter int  DW  = 8,
  localparam int AW  = $clog2(3 * NCH),
  localparam int CW  = 2 * DW
) (
  input logic                   clk,
  input logic                   srst_n,
  input logic                   cnt_en,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_wr,
  input logic [DW-1:0]          bus_wdata,
  input logic [CW-1:0]          cnt,
  input logic [NCH-1:0][CW-1:0] val_w,
  input logic [NCH-1:0]         cap_hold,
  input logic [NCH-1:0]         cmp_hold,
  input logic [NCH-1:0]         cmp_out,
  input logic [NCH-1:0]         chan_flag
);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_en |=> cnt == $past(cnt) + 1'b1);

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !cnt_en |=> $stable(cnt));

  for (genvar c = 0; c < NCH; c++) begin : g_a
    localparam logic [AW-1:0] B = AW'(3 * c);
    logic val_wr;
    assign val_wr = bus_wr && (bus_addr == B + AW'(1) || bus_addr == B + AW'(2));

    a_r4_capture_frozen: assert property (@(posedge clk) disable iff (!srst_n)
      (cap_hold[c] && !val_wr) |=> $stable(val_w[c]));

    a_r5_toggle_flags: assert property (@(posedge clk) disable iff (!srst_n)
      !$stable(cmp_out[c]) |-> chan_flag[c]);

    a_r6_compare_frozen: assert property (@(posedge clk) disable iff (!srst_n)
      cmp_hold[c] |=> $stable(cmp_out[c]));

    a_r7_flag_clear_source: assert property (@(posedge clk) disable iff (!srst_n)
      $fell(chan_flag[c]) |-> $past(bus_wr && bus_addr == B && !bus_wdata[DW-1]));
  end
endmodule

bind tmr_ccp_pair tmr_ccp_chk #(.NCH(NCH), .DW(DW)) i_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .cnt_en    (cnt_en),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .cnt       (cnt),
  .val_w     (val_w),
  .cap_hold  (cap_hold),
  .cmp_hold  (cmp_hold),
  .cmp_out   (cmp_out),
  .chan_flag (chan_flag)
);

// File: tb/test_tmr_ccp_pair.sv
`timescale 1ns/1ps
module test_tmr_ccp_pair;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_en;
  logic [2:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [1:0] cap_in, cmp_out, chan_flag;

  int nchk = 0, nfail = 0;
  logic [15:0] mdl = 16'd0;
  int          exp_ch[$];
  logic [15:0] exp_v[$];
  logic [1:0]  prev_out;

  always #5 clk = ~clk;

  tmr_ccp_pair i_tmr_ccp_pair (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cap_in(cap_in), .cmp_out(cmp_out),
    .chan_flag(chan_flag)
  );

  // counter model per R2
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mdl <= 16'd0;
    else if (cnt_en) mdl <= mdl + 16'd1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every compare toggle must match the queue head (R5)
  always @(negedge clk) begin
    if (!rst_n) prev_out = cmp_out;
    else begin
      for (int c = 0; c < 2; c++) begin
        if (cmp_out[c] != prev_out[c]) begin
          if (exp_ch.size() == 0) begin
            chk(0, "R5/R6 unexpected toggle", c, -1);
          end else begin
            int          ec;
            logic [15:0] ev;
            ec = exp_ch.pop_front();
            ev = exp_v.pop_front();
            chk(ec == c, "R8 toggle channel", c, ec);
            chk(mdl - 16'd1 == ev, "R5 toggle stamp", int'(mdl - 16'd1), int'(ev));
            chk(chan_flag[c] == 1'b1, "R5 flag with toggle", chan_flag[c], 1);
          end
        end
      end
      prev_out = cmp_out;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input int ch, output logic [15:0] v);
    logic [7:0] h, l;
    rd(3'(3 * ch + 1), h);
    rd(3'(3 * ch + 2), l);
    v = {h, l};
  endtask

  // R3 timing: value = counter two clocks after the rising input
  task automatic cap_pulse(input int ch, output logic [15:0] expv);
    @(negedge clk);
    cap_in[ch] = 1'b1;
    expv = cnt_en ? mdl + 16'd2 : mdl;
    repeat (4) @(negedge clk);
    cap_in[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] e, v, t, t2;
    logic [7:0]  b;
    rst_n = 1'b0; cnt_en = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; cap_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cmp_out == 2'b00, "R1 cmp_out", cmp_out, 0);
    chk(chan_flag == 2'b00, "R1 flags", chan_flag, 0);
    rd(3'd0, b); chk(b == 8'h00, "R1 ctrl0", b, 0);
    rd(3'd3, b); chk(b == 8'h00, "R1 ctrl1", b, 0);

    // R2 counter holds while disabled: capture sees 0
    cap_pulse(0, e); rd16(0, v);
    chk(v == 16'h0000, "R2 hold capture", v, 0);

    // R3 capture while counting
    cnt_en = 1'b1;
    repeat (20) @(negedge clk);
    wr(3'd0, 8'h00);
    cap_pulse(0, e); rd16(0, v);
    chk(v == e, "R3 capture value", v, e);
    chk(chan_flag == 2'b01, "R3/R8 flag only ch0", chan_flag, 1);

    // R8 channel 1 capture, R7 bit7=1 keeps flag, bit7=0 clears
    cap_pulse(1, e); rd16(1, v);
    chk(v == e, "R8 ch1 capture value", v, e);
    wr(3'd3, 8'h80);
    chk(chan_flag[1] == 1'b1, "R7 keep on bit7=1", chan_flag[1], 1);
    wr(3'd3, 8'h00);
    chk(chan_flag[1] == 1'b0, "R7 clear ch1", chan_flag[1], 0);
    chk(chan_flag[0] == 1'b1, "R8 ch0 flag untouched", chan_flag[0], 1);

    // R4 capture interlock
    cap_pulse(0, e); t = e;
    wr(3'd0, 8'h00);
    rd(3'd1, b);
    chk(b == t[15:8], "R4 hi byte", b, t[15:8]);
    cap_pulse(0, e);
    chk(chan_flag[0] == 1'b0, "R4 dropped edge no flag", chan_flag[0], 0);
    rd(3'd2, b);
    chk(b == t[7:0], "R4 lo byte coherent", b, t[7:0]);
    cap_pulse(0, e); rd16(0, v);
    chk(v == e, "R4 capture after release", v, e);

    // R7 set wins over same-cycle clear
    wr(3'd0, 8'h00);
    @(negedge clk); cap_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; cap_in[0] = 1'b0;
    #1 chk(chan_flag[0] == 1'b1, "R7 set wins", chan_flag[0], 1);
    wr(3'd0, 8'h00);
    chk(chan_flag[0] == 1'b0, "R7 plain clear", chan_flag[0], 0);

    // R5 compare on ch1
    wr(3'd3, 8'h01);
    t = mdl + 16'd60;
    wr(3'd4, t[15:8]); wr(3'd5, t[7:0]);
    exp_ch.push_back(1); exp_v.push_back(t);
    repeat (80) @(negedge clk);
    chk(cmp_out[1] == 1'b1, "R5 output toggled", cmp_out[1], 1);
    chk(exp_ch.size() == 0, "R5 match seen", exp_ch.size(), 0);

    // R6 compare interlock: pending hi write hides the match
    wr(3'd3, 8'h01);
    t = mdl + 16'd40;
    wr(3'd4, t[15:8] ^ 8'h80); wr(3'd5, t[7:0]);
    wr(3'd4, t[15:8]);
    repeat (70) @(negedge clk);
    chk(chan_flag[1] == 1'b0, "R6 no flag while held", chan_flag[1], 0);
    chk(cmp_out[1] == 1'b1, "R6 no toggle while held", cmp_out[1], 1);
    wr(3'd5, t[7:0]);
    t2 = mdl + 16'd50;
    wr(3'd4, t2[15:8]); wr(3'd5, t2[7:0]);
    exp_ch.push_back(1); exp_v.push_back(t2);
    repeat (70) @(negedge clk);
    chk(cmp_out[1] == 1'b0, "R6 match after release", cmp_out[1], 0);
    chk(exp_ch.size() == 0, "R6 queued match seen", exp_ch.size(), 0);

    // R2 wrap plus R8 independence: ch0 compares across 0xFFFF
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h00); wr(3'd2, 8'h10);
    while (mdl != 16'hFFD0) @(negedge clk);
    exp_ch.push_back(0); exp_v.push_back(16'h0010);
    while (mdl != 16'h0030) @(negedge clk);
    chk(cmp_out[0] == 1'b1, "R2 wrap compare ch0", cmp_out[0], 1);
    chk(cmp_out[1] == 1'b0, "R8 ch1 output steady", cmp_out[1], 0);
    chk(exp_ch.size() == 0, "R2 wrap match seen", exp_ch.size(), 0);
    rd(3'd0, b);
    chk(b == 8'h82, "R7 ctrl readback", b, 8'h82);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule